// File: doc/BRIEF.md
# Partitioned SIMD Saturating ALU

This block is a 64-bit integer arithmetic unit whose carry chain can be cut into independent lanes. A single operation either works on one 64-bit value or on several narrower values side by side: eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. One shared byte-sliced adder does all of the lane arithmetic. The lane width sets where its carries are cut.

Add, subtract, minimum, maximum and absolute value are available with signed or unsigned lane interpretation. Add, subtract and absolute value either wrap around or clamp to the lane limits. A lane-wise 16-bit multiply-accumulate supports dot-product loops. Each byte position has a saturation flag. Every result is registered, so the result and flags for an operation appear one clock after its inputs are presented.

The block has no sequencing state. Its only registers are the output register and a registered copy of the operation controls, which the checks use. There are therefore no states or transitions to name.

Top module: `simd_alu`

## Requirements
- R1: While reset is asserted and after it is released, `result_o` and `satflag_o` read zero. Every operation's result and flags appear at the outputs on the first rising clock edge after its inputs are applied.
- R2: `width_i` selects the lane width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Lane k occupies bits starting at k times the lane width. No carry or borrow crosses a lane boundary.
- R3: With `sat_i`=0, add and subtract produce the lane sum or difference modulo 2^width, and all flags are 0.
- R4: With `sat_i`=1 and `signed_i`=1, an add or subtract that leaves the two's-complement lane range clamps to the most positive value (0111..1) or the most negative value (1000..0), according to the direction of overflow.
- R5: With `sat_i`=1 and `signed_i`=0, an add that overflows clamps to all ones, and a subtract that underflows clamps to zero.
- R6: Min and max select, per lane, the smaller or larger of the two operands, compared signed or unsigned according to `signed_i`. They never set a flag.
- R7: Absolute value acts on `opa_i` only. In unsigned mode it passes the lane through unchanged. In signed mode it negates negative lanes. The most negative lane value becomes the most positive value with a flag when `sat_i`=1, and stays the most negative value without a flag when `sat_i`=0.
- R8: Multiply-accumulate always works on four 16-bit lanes. Each signed 16x16 product is added to the signed 16-bit lane of `acc_i` and clamped to the signed 16-bit range. The operation ignores `width_i`, `signed_i` and `sat_i`.
- R9: `satflag_o` bit j refers to bits 8j+7..8j of the result. When a lane clamps, every flag bit of that lane is set; all other flag bits are 0.
- R10: The `op_i` encoding is 0 add (A+B), 1 subtract (A-B), 2 min, 3 max, 4 absolute value, 5 multiply-accumulate. Codes 6 and 7 produce a zero result and zero flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opa_i | input | 64 | Operand A |
| opb_i | input | 64 | Operand B |
| acc_i | input | 64 | Accumulator lanes for multiply-accumulate |
| width_i | input | 2 | Lane width select (R2) |
| op_i | input | 3 | Operation code (R10) |
| signed_i | input | 1 | 1 = signed lanes, 0 = unsigned |
| sat_i | input | 1 | 1 = saturating, 0 = wrapping |
| result_o | output | 64 | Registered lane results |
| satflag_o | output | 8 | Registered per-byte saturation flags |

## Verification
The assertions check several properties on every cycle, using the registered copy of the controls:
- flags are uniform across each lane at 16, 32 and 64 bits, and across the paired bytes of multiply-accumulate;
- wrapping, min and max operations never raise a flag;
- a flagged signed 8-bit add holds one of the two signed limits.

Only the bench's scenarios can show the following, by comparing every output against a lane-by-lane reference computed with wide integers:
- that the values themselves are right;
- that carries stop at lane boundaries;
- that unsigned clamping goes in the right direction;
- that the most negative value is handled correctly under absolute value;
- that multiply-accumulate ignores the lane controls.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
    localparam logic [2:0] OP_ADD = 3'd0;
    localparam logic [2:0] OP_SUB = 3'd1;
    localparam logic [2:0] OP_MIN = 3'd2;
    localparam logic [2:0] OP_MAX = 3'd3;
    localparam logic [2:0] OP_ABS = 3'd4;
    localparam logic [2:0] OP_MAC = 3'd5;
endpackage

// File: rtl/simd_cut_adder.sv
// Byte-sliced adder; cut[i]=1 starts a new lane at slice i (carry-in = sub).
module simd_cut_adder #(
    parameter int NB = 8,
    parameter int SW = 8
) (
    input  logic [NB*SW-1:0] x_i,
    input  logic [NB*SW-1:0] y_i,
    input  logic             sub_i,
    input  logic [NB-1:0]    cut_i,
    output logic [NB*SW-1:0] sum_o,
    output logic [NB-1:0]    cout_o
);
    logic [NB-1:0] cin;

    for (genvar i = 0; i < NB; i++) begin : g_slice
        if (i == 0) begin : g_first
            assign cin[i] = sub_i;
        end else begin : g_rest
            assign cin[i] = cut_i[i] ? sub_i : cout_o[i-1];
        end
        assign {cout_o[i], sum_o[i*SW +: SW]} =
            {1'b0, x_i[i*SW +: SW]} + {1'b0, y_i[i*SW +: SW] ^ {SW{sub_i}}} + {{SW{1'b0}}, cin[i]};
    end
endmodule

// File: rtl/simd_mac16.sv
// One signed multiply-accumulate lane with clamping to the lane range.
module simd_mac16 #(
    parameter int MW = 16
) (
    input  logic [MW-1:0] a_i,
    input  logic [MW-1:0] b_i,
    input  logic [MW-1:0] c_i,
    output logic [MW-1:0] r_o,
    output logic          sat_o
);
    localparam int PW = 2*MW + 1;
    localparam logic signed [PW-1:0] HI = PW'((1 <<< (MW-1)) - 1);
    localparam logic signed [PW-1:0] LO = -PW'(1 <<< (MW-1));

    logic signed [2*MW-1:0] prod;
    logic signed [PW-1:0]   total;

    always_comb begin
        prod  = $signed(a_i) * $signed(b_i);
        total = PW'(prod) + PW'($signed(c_i));
        sat_o = 1'b0;
        r_o   = total[MW-1:0];
        if (total > HI) begin
            r_o   = {1'b0, {(MW-1){1'b1}}};
            sat_o = 1'b1;
        end else if (total < LO) begin
            r_o   = {1'b1, {(MW-1){1'b0}}};
            sat_o = 1'b1;
        end
    end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
    import simd_alu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int SW     = 8,
    parameter int MW     = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [DATA_W-1:0]               opa_i,
    input  logic [DATA_W-1:0]               opb_i,
    input  logic [DATA_W-1:0]               acc_i,
    input  logic [$clog2($clog2(DATA_W/SW)+1)-1:0] width_i,
    input  logic [2:0]                      op_i,
    input  logic                            signed_i,
    input  logic                            sat_i,
    output logic [DATA_W-1:0]               result_o,
    output logic [DATA_W/SW-1:0]            satflag_o
);
    localparam int NB    = DATA_W / SW;
    localparam int NMAC  = DATA_W / MW;
    localparam int BPM   = MW / SW;
    localparam int SEL_W = $clog2($clog2(NB) + 1);

    logic [NB-1:0]     lane_m1;
    logic [NB-1:0]     cut;
    logic              sub;
    logic [DATA_W-1:0] add_x, add_y, sum;
    logic [NB-1:0]     cout;
    logic [DATA_W-1:0] alu_res, mac_res, nxt_res;
    logic [NB-1:0]     alu_flag, mac_flag, nxt_flag;

    // registered copy of the controls, used by the checks
    logic [2:0]       q_op;
    logic [SEL_W-1:0] q_width;
    logic             q_signed, q_sat;

    assign lane_m1 = NB'((1 << width_i) - 1);
    assign sub     = (op_i != OP_ADD);
    assign add_x   = (op_i == OP_ABS) ? '0 : opa_i;
    assign add_y   = (op_i == OP_ABS) ? opa_i : opb_i;

    for (genvar i = 0; i < NB; i++) begin : g_cut
        assign cut[i] = ((NB'(i) & lane_m1) == '0);
    end

    simd_cut_adder #(.NB(NB), .SW(SW)) u_add (
        .x_i(add_x), .y_i(add_y), .sub_i(sub), .cut_i(cut),
        .sum_o(sum), .cout_o(cout)
    );

    // per-byte result select using the flags of the lane's top byte
    always_comb begin
        int            t;
        logic          xa, yb, rm, ct, am, ovf_s, uov, lt;
        logic [SW-1:0] ab, bb, sb, hi_lim, lo_lim;
        alu_res  = '0;
        alu_flag = '0;
        for (int i = 0; i < NB; i++) begin
            t      = i | int'(lane_m1);
            xa     = add_x[t*SW + SW-1];
            yb     = add_y[t*SW + SW-1] ^ sub;
            rm     = sum[t*SW + SW-1];
            ct     = cout[t];
            am     = opa_i[t*SW + SW-1];
            ovf_s  = (xa == yb) && (rm != xa);
            uov    = sub ? ~ct : ct;
            lt     = signed_i ? (rm ^ ovf_s) : ~ct;
            ab     = opa_i[i*SW +: SW];
            bb     = opb_i[i*SW +: SW];
            sb     = sum[i*SW +: SW];
            hi_lim = (i == t) ? {1'b0, {(SW-1){1'b1}}} : '1;
            lo_lim = (i == t) ? {1'b1, {(SW-1){1'b0}}} : '0;
            case (op_i)
                OP_ADD, OP_SUB: begin
                    alu_res[i*SW +: SW] = sb;
                    if (sat_i && signed_i && ovf_s) begin
                        alu_res[i*SW +: SW] = xa ? lo_lim : hi_lim;
                        alu_flag[i]         = 1'b1;
                    end else if (sat_i && !signed_i && uov) begin
                        alu_res[i*SW +: SW] = sub ? '0 : '1;
                        alu_flag[i]         = 1'b1;
                    end
                end
                OP_MIN: alu_res[i*SW +: SW] = lt ? ab : bb;
                OP_MAX: alu_res[i*SW +: SW] = lt ? bb : ab;
                OP_ABS: begin
                    alu_res[i*SW +: SW] = ab;
                    if (signed_i && am) begin
                        alu_res[i*SW +: SW] = sb;
                        if (sat_i && ovf_s) begin
                            alu_res[i*SW +: SW] = hi_lim;
                            alu_flag[i]         = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    for (genvar m = 0; m < NMAC; m++) begin : g_mac
        logic msat;
        simd_mac16 #(.MW(MW)) u_mac (
            .a_i(opa_i[m*MW +: MW]), .b_i(opb_i[m*MW +: MW]), .c_i(acc_i[m*MW +: MW]),
            .r_o(mac_res[m*MW +: MW]), .sat_o(msat)
        );
        assign mac_flag[m*BPM +: BPM] = {BPM{msat}};
    end

    always_comb begin
        nxt_res  = '0;
        nxt_flag = '0;
        if (op_i == OP_MAC) begin
            nxt_res  = mac_res;
            nxt_flag = mac_flag;
        end else if (op_i <= OP_ABS) begin
            nxt_res  = alu_res;
            nxt_flag = alu_flag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o  <= '0;
            satflag_o <= '0;
            q_op      <= '0;
            q_width   <= '0;
            q_signed  <= 1'b0;
            q_sat     <= 1'b0;
        end else begin
            result_o  <= nxt_res;
            satflag_o <= nxt_flag;
            q_op      <= op_i;
            q_width   <= width_i;
            q_signed  <= signed_i;
            q_sat     <= sat_i;
        end
    end

    // R9: flags uniform within a lane
    a_r9_flags_w64: assert property (@(posedge clk) disable iff (!rst_n)
        (q_width == SEL_W'(3) && q_op != OP_MAC) |-> (satflag_o == '0 || satflag_o == '1));
    a_r9_flags_w32: assert property (@(posedge clk) disable iff (!rst_n)
        (q_width == SEL_W'(2) && q_op != OP_MAC) |->
        ((satflag_o[3:0] == 4'h0 || satflag_o[3:0] == 4'hF) &&
         (satflag_o[7:4] == 4'h0 || satflag_o[7:4] == 4'hF)));
    a_r9_flags_w16: assert property (@(posedge clk) disable iff (!rst_n)
        (q_width == SEL_W'(1) || q_op == OP_MAC) |->
        (satflag_o[0] == satflag_o[1] && satflag_o[2] == satflag_o[3] &&
         satflag_o[4] == satflag_o[5] && satflag_o[6] == satflag_o[7]));
    // R8: multiply-accumulate pairs bytes regardless of lane width
    a_r8_mac_pairs: assert property (@(posedge clk) disable iff (!rst_n)
        (q_op == OP_MAC && q_width == SEL_W'(0)) |-> (satflag_o[0] == satflag_o[1]));
    // R3: wrapping operations never flag
    a_r3_wrap_noflag: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_sat && q_op != OP_MAC) |-> (satflag_o == '0));
    // R6: min/max never flag
    a_r6_minmax_noflag: assert property (@(posedge clk) disable iff (!rst_n)
        (q_op == OP_MIN || q_op == OP_MAX) |-> (satflag_o == '0));
    // R4: a flagged signed byte add holds a signed limit
    a_r4_byte_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (q_op == OP_ADD && q_width == SEL_W'(0) && q_signed && satflag_o[0]) |->
        (result_o[SW-1:0] == {1'b0, {(SW-1){1'b1}}} || result_o[SW-1:0] == {1'b1, {(SW-1){1'b0}}}));
    // R10: reserved codes give zero
    a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (q_op > OP_MAC) |-> (result_o == '0 && satflag_o == '0));
endmodule

// File: tb/tb_simd_alu.sv
module tb_simd_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] opa = '0, opb = '0, acc = '0;
    logic [1:0]  width = '0;
    logic [2:0]  op = '0;
    logic        sg = 1'b0, st = 1'b0;
    logic [63:0] result;
    logic [7:0]  satflag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    simd_alu dut (
        .clk(clk), .rst_n(rst_n), .opa_i(opa), .opb_i(opb), .acc_i(acc),
        .width_i(width), .op_i(op), .signed_i(sg), .sat_i(st),
        .result_o(result), .satflag_o(satflag)
    );

    // Behavioural lane model: returns {flags, result}
    function automatic logic [71:0] model(input logic [2:0] o, input logic [63:0] a, b, c,
                                          input logic [1:0] w, input logic s, input logic t);
        logic [63:0] res = '0;
        logic [7:0]  flg = '0;
        if (o == 3'd5) begin
            for (int k = 0; k < 4; k++) begin
                int p;
                p = int'($signed(a[k*16 +: 16])) * int'($signed(b[k*16 +: 16])) + int'($signed(c[k*16 +: 16]));
                if (p > 32767) begin p = 32767; flg[k*2 +: 2] = 2'b11; end
                else if (p < -32768) begin p = -32768; flg[k*2 +: 2] = 2'b11; end
                res[k*16 +: 16] = p[15:0];
            end
        end else if (o <= 3'd4) begin
            int lw = 8 << w;
            int nl = 64 / lw;
            logic [63:0] mask = (lw == 64) ? '1 : ((64'd1 << lw) - 64'd1);
            for (int k = 0; k < nl; k++) begin
                logic [63:0] la, lb;
                logic signed [66:0] xa, xb, r, hi, lo;
                bit f = 1'b0;
                la = (a >> (k*lw)) & mask;
                lb = (b >> (k*lw)) & mask;
                xa = $signed({3'b000, la});
                xb = $signed({3'b000, lb});
                if (s && la[lw-1]) xa = xa - (67'sd1 <<< lw);
                if (s && lb[lw-1]) xb = xb - (67'sd1 <<< lw);
                hi = s ? ((67'sd1 <<< (lw-1)) - 67'sd1) : ((67'sd1 <<< lw) - 67'sd1);
                lo = s ? -(67'sd1 <<< (lw-1)) : 67'sd0;
                case (o)
                    3'd0: r = xa + xb;
                    3'd1: r = xa - xb;
                    3'd2: r = (xa < xb) ? xa : xb;
                    3'd3: r = (xa > xb) ? xa : xb;
                    default: r = (s && xa < 0) ? -xa : xa;
                endcase
                if (t && (r > hi || r < lo)) begin
                    r = (r > hi) ? hi : lo;
                    f = 1'b1;
                end
                res = res | ((r[63:0] & mask) << (k*lw));
                if (f) for (int j = 0; j < lw/8; j++) flg[k*(lw/8) + j] = 1'b1;
            end
        end
        return {flg, res};
    endfunction

    task automatic run(input logic [2:0] o, input logic [63:0] a, b, c,
                       input logic [1:0] w, input logic s, input logic t, input string tag);
        logic [71:0] exp;
        @(negedge clk);
        op = o; opa = a; opb = b; acc = c; width = w; sg = s; st = t;
        exp = model(o, a, b, c, w, s, t);
        @(negedge clk);
        checks++;
        if ({satflag, result} !== exp) begin
            fails++;
            $display("FAIL %s op=%0d w=%0d s=%0b t=%0b: got flags=%h res=%h, expected flags=%h res=%h",
                     tag, o, w, s, t, satflag, result, exp[71:64], exp[63:0]);
        end
    endtask

    function automatic string tag_of(input logic [2:0] o, input logic s, input logic t);
        case (o)
            3'd0, 3'd1: return !t ? "R3" : (s ? "R4" : "R5");
            3'd2, 3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            default: return "R10";
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        checks++; // R1: outputs zero in reset
        if (result !== '0 || satflag !== '0) begin
            fails++;
            $display("FAIL R1 reset: got res=%h flags=%h, expected 0/0", result, satflag);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++; // R1: zero after release with zero inputs
        if (result !== '0 || satflag !== '0) begin
            fails++;
            $display("FAIL R1 after reset: got res=%h flags=%h, expected 0/0", result, satflag);
        end
        // R2: carry cut at every lane width
        for (int w = 0; w < 4; w++)
            run(3'd0, 64'h00FF_00FF_FFFF_FFFF, 64'h0001_0001_0001_0001, '0, 2'(w), 1'b0, 1'b0, "R2");
        run(3'd1, 64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001, '0, 2'd1, 1'b0, 1'b0, "R2");
        // R4 / R9: signed clamps both directions
        run(3'd0, 64'h7F00_7FFF_7FFF_FFFF, 64'h0100_0001_0001_0001, '0, 2'd1, 1'b1, 1'b1, "R4 R9");
        run(3'd1, 64'h8000_0000_8000_0000, 64'h0000_0001_0000_0001, '0, 2'd2, 1'b1, 1'b1, "R4 R9");
        run(3'd0, 64'h7F80_7F80_7F80_7F80, 64'h0180_0180_0180_0180, '0, 2'd0, 1'b1, 1'b1, "R4");
        // R5: unsigned clamps
        run(3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, '0, 2'd3, 1'b0, 1'b1, "R5 R9");
        run(3'd1, 64'h0010_0020_0030_0040, 64'h0020_0010_0040_0030, '0, 2'd1, 1'b0, 1'b1, "R5");
        // R6
        run(3'd2, 64'h80FF_0102_7F00_FF01, 64'h7F01_0201_8000_01FF, '0, 2'd0, 1'b1, 1'b0, "R6");
        run(3'd3, 64'h80FF_0102_7F00_FF01, 64'h7F01_0201_8000_01FF, '0, 2'd0, 1'b0, 1'b1, "R6");
        // R7: most negative under both modes, unsigned passthrough
        run(3'd4, 64'h8000_FFFF_0005_8000, '0, '0, 2'd1, 1'b1, 1'b1, "R7");
        run(3'd4, 64'h8000_FFFF_0005_8000, '0, '0, 2'd1, 1'b1, 1'b0, "R7");
        run(3'd4, 64'h8000_FFFF_0005_8000, '0, '0, 2'd1, 1'b0, 1'b1, "R7");
        // R8: clamp both ways, ignoring width/signed/sat
        run(3'd5, 64'h7FFF_8000_0003_7FFF, 64'h7FFF_7FFF_FFFE_0002, 64'h0001_FFFF_0010_8000, 2'd3, 1'b0, 1'b0, "R8");
        // R10: reserved codes
        run(3'd6, '1, '1, '1, 2'd0, 1'b1, 1'b1, "R10");
        run(3'd7, '1, 64'h1, '1, 2'd1, 1'b0, 1'b1, "R10");
        // mixed patterns
        for (int n = 0; n < 400; n++) begin
            logic [63:0] a, b, c;
            logic [2:0]  o;
            logic        s, t;
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            c = {$urandom, $urandom};
            if (n % 4 == 1) a = 64'h7F7F_7F7F_8080_8080 ^ {32'h0, $urandom & 32'h0101_0101};
            if (n % 4 == 2) b = 64'h8000_8000_7FFF_7FFF;
            o = 3'($urandom % 8);
            s = 1'($urandom);
            t = 1'($urandom);
            run(o, a, b, c, 2'($urandom), s, t, tag_of(o, s, t));
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule